// File: doc/BRIEF.md
# Task-Switched Paged Address Mapper

This block translates the 16-bit logical address of an 8-bit CPU into a wider physical address. The logical space is cut into sixteen 4 KB pages. Address bits 15:12 pick a page entry, and that entry supplies the upper physical address bits. Several complete sets of sixteen entries are stored, one per task. A single task-register write switches the whole mapping, so a context switch costs one bus cycle.

Each entry also carries protection flags. A write to a read-only page is stopped through a write-inhibit output. A write to a page marked for interrupt latches an IRQ that stays high until software clears it. The mapper's own register window is decoded from the logical address, so it can be reached from any mapping. The topmost page can be tied to task 0's entry, which gives every task a shared window.

After reset the extension is off and the mapper passes the address through unchanged. Software turns it on with a two-write unlock sequence. Every clock edge is one bus cycle.

Top module: `task_page_mapper`

## Requirements
- R1: Asynchronous reset (rst_ni low) disables the extension, clears the IRQ and selects task 0. Every entry of every task is reset to identity (page n maps to physical page n) with all flags clear.
- R2: While the extension is disabled, phys_addr_o equals the logical address zero-extended. Writes outside the register window are never inhibited and never raise the IRQ, whatever the entries or the task register hold.
- R3: The extension turns on only when two consecutive writes to the register window both go to offset 0x23, the first with data 0xA5 and the second with 0x5A. Any other window write, or any other value, between or instead of these breaks the sequence. Once on, the extension stays on until reset.
- R4: The register window is logical 0xFFC0 to 0xFFFF (offset = address bits 5:0). It is decoded before translation, so it works in every mapping. Any write to it asserts wr_inhibit_o in that cycle.
- R5: A window write to offset 0x00+n sets the physical page number of page n in the edit task (offset 0x21). A write to offset 0x10+n sets the flags of that page: bit 0 makes the page read-only, bit 1 enables IRQ-on-write, and bit 2 is stored but has no effect.
- R6: While enabled, phys_addr_o = {entry[task][addr 15:12], addr 11:0}.
- R7: A write to offset 0x20 loads the task number. The new mapping applies from the next bus cycle.
- R8: While enabled, logical page 15 always uses task 0's entry, whatever task is active.
- R9: While enabled, a CPU write to a read-only page asserts wr_inhibit_o combinationally in that cycle. Reads are never inhibited.
- R10: While enabled, a write to a page with the IRQ flag sets irq_o from the next cycle on. Reads never set it. irq_o stays set until a window write to offset 0x22 clears it.
- R11: Flags written while the extension was disabled take effect once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, one bus cycle per edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | Logical CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| phys_addr_o | output | PPN_W+12 | Translated physical address |
| wr_inhibit_o | output | 1 | Blocks the memory write in this cycle |
| irq_o | output | 1 | Latched protection interrupt |

## Verification
The bench goes after several corner cases.
- Broken unlock sequences, one with an unrelated window write in between and one with a wrong second key. A design that only looked at the last key would switch on early, and the next read would come back remapped.
- The switch from one task to another. The bench checks the very next read under the new task. A design that delayed the switch would keep returning the old page.
- The shared top page while a task holds a different entry for it. A design that ignored this would return that task's entry.
- IRQ behaviour. The bench checks that the IRQ survives unrelated cycles and that reads do not raise it. A design that treated the flag as a pulse, or that decoded reads as writes, would fail one of these checks.
- Flags written before enabling. The bench checks that they take hold only once the extension is on.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam logic [7:0] UNLOCK_KEY_A = 8'hA5;
  localparam logic [7:0] UNLOCK_KEY_B = 8'h5A;
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_TASK   = 6'h20;
  localparam logic [OFS_W-1:0] OFS_EDIT   = 6'h21;
  localparam logic [OFS_W-1:0] OFS_IRQCLR = 6'h22;
  localparam logic [OFS_W-1:0] OFS_UNLOCK = 6'h23;
  localparam int PAGE_BITS = 4;
  localparam int NUM_PAGES = 1 << PAGE_BITS;

  typedef struct packed {
    logic rsvd;
    logic irq_wr;
    logic ro;
  } page_flags_t;
endpackage

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
#(
  parameter int TASK_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 win_wr_i,
  input  logic [OFS_W-1:0]     ofs_i,
  input  logic [7:0]           data_i,
  input  logic                 irq_set_i,
  output logic                 en_o,
  output logic [TASK_W-1:0]    task_o,
  output logic [TASK_W-1:0]    edit_o,
  output logic                 tbl_we_o,
  output logic                 tbl_flags_o,
  output logic [PAGE_BITS-1:0] tbl_page_o,
  output logic                 irq_o
);
  logic              en_q, stage_q, irq_q;
  logic [TASK_W-1:0] task_q, edit_q;
  logic              wr_task, wr_edit, wr_clr, wr_unl;

  assign wr_task = win_wr_i && (ofs_i == OFS_TASK);
  assign wr_edit = win_wr_i && (ofs_i == OFS_EDIT);
  assign wr_clr  = win_wr_i && (ofs_i == OFS_IRQCLR);
  assign wr_unl  = win_wr_i && (ofs_i == OFS_UNLOCK);

  assign tbl_we_o    = win_wr_i && !ofs_i[5];
  assign tbl_flags_o = ofs_i[4];
  assign tbl_page_o  = ofs_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      stage_q <= 1'b0;
      task_q  <= '0;
      edit_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (win_wr_i) begin
        // unlock needs back-to-back window writes
        if (wr_unl && data_i == UNLOCK_KEY_A) begin
          stage_q <= 1'b1;
        end else begin
          stage_q <= 1'b0;
          if (wr_unl && stage_q && data_i == UNLOCK_KEY_B) en_q <= 1'b1;
        end
      end
      if (wr_task) task_q <= data_i[TASK_W-1:0];
      if (wr_edit) edit_q <= data_i[TASK_W-1:0];
      if (wr_clr)         irq_q <= 1'b0;
      else if (irq_set_i) irq_q <= 1'b1;
    end
  end

  assign en_o   = en_q;
  assign task_o = task_q;
  assign edit_o = edit_q;
  assign irq_o  = irq_q;

  // R3
  enable_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !wr_clr) |=> irq_q);
  // R10
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(irq_set_i));
  // R7
  task_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_task |=> $stable(task_q));
endmodule

// File: rtl/tpm_table.sv
module tpm_table
  import tpm_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int TASK_W    = 2,
  parameter int PPN_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 wr_flags_i,
  input  logic [TASK_W-1:0]    wr_task_i,
  input  logic [PAGE_BITS-1:0] wr_page_i,
  input  logic [7:0]           wr_data_i,
  input  logic [TASK_W-1:0]    rd_task_i,
  input  logic [PAGE_BITS-1:0] rd_page_i,
  output logic [PPN_W-1:0]     rd_ppn_o,
  output page_flags_t          rd_flags_o
);
  logic [PPN_W-1:0] ppn_q [NUM_TASKS][NUM_PAGES];
  page_flags_t      flg_q [NUM_TASKS][NUM_PAGES];
  logic [PPN_W+7:0] data_ext;

  assign data_ext = {{PPN_W{1'b0}}, wr_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_TASKS; t++) begin
        for (int p = 0; p < NUM_PAGES; p++) begin
          ppn_q[t][p] <= PPN_W'(p);
          flg_q[t][p] <= '0;
        end
      end
    end else if (we_i) begin
      if (wr_flags_i) flg_q[wr_task_i][wr_page_i] <= page_flags_t'(wr_data_i[2:0]);
      else            ppn_q[wr_task_i][wr_page_i] <= data_ext[PPN_W-1:0];
    end
  end

  assign rd_ppn_o   = ppn_q[rd_task_i][rd_page_i];
  assign rd_flags_o = flg_q[rd_task_i][rd_page_i];
endmodule

// File: rtl/tpm_xlate.sv
module tpm_xlate
  import tpm_pkg::*;
#(
  parameter int TASK_W     = 2,
  parameter int PPN_W      = 8,
  parameter bit COMMON_TOP = 1'b1
) (
  input  logic [PAGE_BITS-1:0] page_i,
  input  logic                 rw_i,
  input  logic                 win_hit_i,
  input  logic                 en_i,
  input  logic [TASK_W-1:0]    task_i,
  output logic [TASK_W-1:0]    lk_task_o,
  input  logic [PPN_W-1:0]     lk_ppn_i,
  input  page_flags_t          lk_flags_i,
  output logic [PPN_W-1:0]     ppn_o,
  output logic                 inhibit_o,
  output logic                 irq_set_o
);
  logic prot_wr;
  logic rsvd_unused;

  generate
    if (COMMON_TOP) begin : g_common
      assign lk_task_o = (page_i == PAGE_BITS'(NUM_PAGES-1)) ? '0 : task_i;
    end else begin : g_private
      assign lk_task_o = task_i;
    end
  endgenerate

  assign rsvd_unused = lk_flags_i.rsvd;
  assign ppn_o     = en_i ? lk_ppn_i : PPN_W'(page_i);
  assign prot_wr   = en_i && !win_hit_i && !rw_i;
  assign inhibit_o = (win_hit_i && !rw_i) || (prot_wr && lk_flags_i.ro);
  assign irq_set_o = prot_wr && lk_flags_i.irq_wr;
endmodule

// File: rtl/task_page_mapper.sv
module task_page_mapper
  import tpm_pkg::*;
#(
  parameter int          PPN_W      = 8,
  parameter int          NUM_TASKS  = 4,
  parameter logic [15:0] WIN_BASE   = 16'hFFC0,
  parameter bit          COMMON_TOP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      cpu_addr_i,
  input  logic [7:0]       cpu_data_i,
  input  logic             cpu_rw_i,
  output logic [PPN_W+11:0] phys_addr_o,
  output logic             wr_inhibit_o,
  output logic             irq_o
);
  localparam int TASK_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1;

  logic                 win_hit, win_wr, en, irq_set;
  logic [TASK_W-1:0]    act_task, edit_task, lk_task;
  logic                 tbl_we, tbl_flags;
  logic [PAGE_BITS-1:0] tbl_page, page;
  logic [PPN_W-1:0]     lk_ppn, ppn;
  page_flags_t          lk_flags;

  assign page    = cpu_addr_i[15:12];
  assign win_hit = (cpu_addr_i[15:OFS_W] == WIN_BASE[15:OFS_W]);
  assign win_wr  = win_hit && !cpu_rw_i;

  tpm_ctrl #(.TASK_W(TASK_W)) ctrl_i (
    .clk_i, .rst_ni,
    .win_wr_i(win_wr), .ofs_i(cpu_addr_i[OFS_W-1:0]), .data_i(cpu_data_i),
    .irq_set_i(irq_set), .en_o(en), .task_o(act_task), .edit_o(edit_task),
    .tbl_we_o(tbl_we), .tbl_flags_o(tbl_flags), .tbl_page_o(tbl_page),
    .irq_o(irq_o)
  );

  tpm_table #(.NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W), .PPN_W(PPN_W)) table_i (
    .clk_i, .rst_ni,
    .we_i(tbl_we), .wr_flags_i(tbl_flags), .wr_task_i(edit_task),
    .wr_page_i(tbl_page), .wr_data_i(cpu_data_i),
    .rd_task_i(lk_task), .rd_page_i(page),
    .rd_ppn_o(lk_ppn), .rd_flags_o(lk_flags)
  );

  tpm_xlate #(.TASK_W(TASK_W), .PPN_W(PPN_W), .COMMON_TOP(COMMON_TOP)) xlate_i (
    .page_i(page), .rw_i(cpu_rw_i), .win_hit_i(win_hit), .en_i(en),
    .task_i(act_task), .lk_task_o(lk_task), .lk_ppn_i(lk_ppn),
    .lk_flags_i(lk_flags), .ppn_o(ppn), .inhibit_o(wr_inhibit_o),
    .irq_set_o(irq_set)
  );

  assign phys_addr_o = {ppn, cpu_addr_i[11:0]};

  // R2
  disabled_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (phys_addr_o == (PPN_W+12)'(cpu_addr_i)));
  // R2
  disabled_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !$rose(irq_o));
  // R4
  win_write_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr |-> wr_inhibit_o);
  // R9
  read_never_inhibited_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rw_i |-> !wr_inhibit_o);
endmodule

// File: tb/task_page_mapper_tb_top.sv
module task_page_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] cpu_addr_i;
  logic [7:0]  cpu_data_i;
  logic        cpu_rw_i;
  logic [19:0] phys_addr_o;
  logic        wr_inhibit_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  task_page_mapper dut_i (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_rw_i,
    .phys_addr_o, .wr_inhibit_o, .irq_o
  );

  // {addr, rw, expected phys, expected inhibit}, walked with task 1 active
  localparam int NV = 7;
  localparam logic [37:0] VEC [NV] = '{
    {16'h3ABC, 1'b1, 20'h91ABC, 1'b0},  // R6
    {16'h0123, 1'b1, 20'h00123, 1'b0},  // R6
    {16'hF000, 1'b1, 20'h0F000, 1'b0},  // R8
    {16'h5000, 1'b1, 20'h05000, 1'b0},  // R9
    {16'h5010, 1'b0, 20'h05010, 1'b1},  // R9
    {16'h3010, 1'b0, 20'h91010, 1'b0},  // R6
    {16'h7000, 1'b0, 20'h07000, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic rw, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_rw_i = rw; cpu_data_i = d;
    #5;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(a, 1'b0, d);
  endtask

  task automatic rd(input logic [15:0] a);
    bus(a, 1'b1, 8'h00);
  endtask

  initial begin
    rst_ni = 1'b0; cpu_addr_i = '0; cpu_rw_i = 1'b1; cpu_data_i = '0;
    rd(16'h3123);
    check("R1 reset identity", phys_addr_o, 20'h03123);
    check("R1 reset irq", irq_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // configure while disabled
    wr(16'hFFE1, 8'h00);
    wr(16'hFFC3, 8'h80);
    wr(16'hFFD4, 8'h01);
    rd(16'h3000);
    check("R2 disabled passthrough", phys_addr_o, 20'h03000);
    wr(16'h4000, 8'h55);
    check("R2 disabled no inhibit", wr_inhibit_o, 0);
    rd(16'h0000);
    check("R2 disabled no irq", irq_o, 0);

    // broken unlock sequences
    wr(16'hFFE3, 8'hA5); wr(16'hFFE1, 8'h00); wr(16'hFFE3, 8'h5A);
    rd(16'h3000);
    check("R3 interrupted unlock", phys_addr_o, 20'h03000);
    wr(16'hFFE3, 8'hA5); wr(16'hFFE3, 8'h11); wr(16'hFFE3, 8'h5A);
    rd(16'h3000);
    check("R3 wrong key", phys_addr_o, 20'h03000);
    wr(16'hFFE3, 8'hA5); wr(16'hFFE3, 8'h5A);
    rd(16'h3000);
    check("R3 R6 unlocked remap", phys_addr_o, 20'h80000);

    // task 1 entries
    wr(16'hFFE1, 8'h01);
    wr(16'hFFC3, 8'h91);
    wr(16'hFFCF, 8'hEE);
    wr(16'hFFD5, 8'h03);
    wr(16'hFFD6, 8'h02);
    wr(16'hFFD7, 8'h04);
    check("R4 window write inhibited", wr_inhibit_o, 1);
    rd(16'h3000);
    check("R7 task 0 still active", phys_addr_o, 20'h80000);
    wr(16'hFFE0, 8'h01);
    rd(16'h3000);
    check("R7 switch next cycle", phys_addr_o, 20'h91000);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][37:22], VEC[i][21], 8'hAA);
      check("R6 R8 R9 vector phys", phys_addr_o, VEC[i][20:1]);
      check("R9 R5 vector inhibit", wr_inhibit_o, VEC[i][0]);
    end

    rd(16'h0000);
    check("R10 irq latched and held", irq_o, 1);
    wr(16'hFFE2, 8'h00);
    rd(16'h0000);
    check("R10 irq cleared", irq_o, 0);
    rd(16'h6000);
    rd(16'h0000);
    check("R10 read does not set irq", irq_o, 0);
    wr(16'h6000, 8'h12);
    check("R9 irq-only page writable", wr_inhibit_o, 0);
    rd(16'h0000);
    check("R10 irq on write", irq_o, 1);
    rd(16'h1000);
    check("R10 irq held", irq_o, 1);
    wr(16'hFFE2, 8'h00);
    rd(16'h0000);
    check("R10 irq clear again", irq_o, 0);

    wr(16'hFFE0, 8'h00);
    rd(16'h3000);
    check("R7 back to task 0", phys_addr_o, 20'h80000);
    wr(16'h4000, 8'h66);
    check("R11 early flag active", wr_inhibit_o, 1);
    rd(16'hF123);
    check("R8 top page task 0", phys_addr_o, 20'h0F123);

    @(negedge clk_i); rst_ni = 1'b0;
    #5;
    check("R1 reset clears irq", irq_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    rd(16'h3000);
    check("R1 R3 reset disables", phys_addr_o, 20'h03000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule